// File: doc/BRIEF.md
# Iterative IDEA Block Encryptor

This block encrypts one 64-bit block with the IDEA cipher. It reuses one round of hardware over nine steps, one step per clock. The 64-bit block is split into four 16-bit words, with the first word in the most significant bits. Eight full rounds are followed by an output transformation. The only operations are bitwise XOR, addition modulo 2^16 and multiplication modulo 2^16+1.

A start strobe loads the plaintext. On each step the block presents a step index and expects the matching subkeys on a 96-bit input in the same cycle. An external key store or schedule supplies them. When the last step completes, the ciphertext is registered and a one-cycle done pulse marks it valid.

Top module: `idea_iter_enc`

## Requirements
- R1: The block is taken as four 16-bit words with word 1 in bits 63:48 and word 4 in bits 15:0. The ciphertext uses the same word layout.
- R2: Multiplication is modulo 65537. An all-zero 16-bit operand stands for 65536, and a product equal to 65536 is returned as 0.
- R3: Each of the eight full rounds does the following, with ⊙ for the multiply and + for the add:
  - a=X1⊙K1, b=X2+K2, c=X3+K3, d=X4⊙K4.
  - e=(a^c)⊙K5, f=(e+(b^d))⊙K6, g=e+f.
  - The new state is {a^f, c^f, b^g, d^g}, so the middle words leave the round exchanged.
- R4: The final step outputs {X1⊙K1, X3+K2, X2+K3, X4⊙K4} from the state after round 8. This undoes the last exchange.
- R5: Subkeys arrive on key_i, with K1 in bits 95:80 down to K6 in bits 15:0. key_idx_o equals the step number: 0 to 7 for the rounds and 8 for the final step, which uses only bits 95:32. The index rises by one per clock while busy and is 0 when idle.
- R6: If start_i is sampled high while idle on clock edge E0, done_o is high for exactly one cycle after edge E9, and ct_o holds the ciphertext from then on.
- R7: start_i is ignored while an encryption is in progress. A strobe with a different plaintext mid-run does not change that run's ciphertext or its timing.
- R8: After reset, done_o is 0, key_idx_o is 0 and ct_o is 0. ct_o changes only in the cycle in which done_o is high.
- R9: With key 0001 0002 ... 0008 (hex words) and plaintext 0000 0001 0002 0003, the ciphertext is 11FB ED2B 0198 6DE5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin encryption of pt_i when idle |
| pt_i | input | 64 | Plaintext block |
| key_idx_o | output | 4 | Step number whose subkeys are required |
| key_i | input | 96 | Subkeys K1..K6 for the current step |
| ct_o | output | 64 | Ciphertext, valid from the done pulse |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest cases to reach are the zero-as-65536 paths in the multiplier. In those cases an operand, or an intermediate product deep inside a round, is zero or equals 65536. Random data almost never produces them. The stimulus therefore includes all-zero and all-ones plaintexts and keys, which drive zero operands into the first multiplications and keep them in play in later rounds. A strobe is also injected in the middle of a run to show that the strobe is ignored.

// File: rtl/idea_pkg.sv
package idea_pkg;
  parameter int W      = 16;
  parameter int NWORD  = 4;
  parameter int NROUND = 8;
  parameter int NKEY   = 6;
  localparam int BLKW  = W * NWORD;
  localparam int KEYW  = W * NKEY;
  localparam int IDXW  = $clog2(NROUND + 1);
  typedef logic [W-1:0] word_t;
endpackage

// File: rtl/idea_mulmod.sv
module idea_mulmod #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o
);
  localparam logic [W+1:0] MOD = (W+2)'(1) << W | (W+2)'(1);

  logic [W:0]     a_x, b_x;
  logic [2*W+1:0] prod;
  logic [W+1:0]   lo_x, hi_x, res;

  // zero encodes 2^W
  assign a_x  = (a_i == '0) ? ((W+1)'(1) << W) : {1'b0, a_i};
  assign b_x  = (b_i == '0) ? ((W+1)'(1) << W) : {1'b0, b_i};
  assign prod = {{(W+1){1'b0}}, a_x} * {{(W+1){1'b0}}, b_x};
  assign lo_x = {2'b00, prod[W-1:0]};
  assign hi_x = {1'b0, prod[2*W:W]};

  // 2^W == -1 mod (2^W+1): result = lo - hi
  always_comb begin
    if (lo_x >= hi_x) res = lo_x - hi_x;
    else              res = lo_x + MOD - hi_x;
  end

  assign y_o = res[W-1:0];
endmodule

// File: rtl/idea_round.sv
module idea_round
  import idea_pkg::*;
(
  input  logic [BLKW-1:0] x_i,
  input  logic [KEYW-1:0] k_i,
  output logic [BLKW-1:0] rnd_o,
  output logic [BLKW-1:0] xf_o
);
  word_t x [NWORD];
  word_t k [NKEY];

  for (genvar g = 0; g < NWORD; g++) begin : g_xw
    assign x[g] = x_i[BLKW-1-g*W -: W];
  end
  for (genvar g = 0; g < NKEY; g++) begin : g_kw
    assign k[g] = k_i[KEYW-1-g*W -: W];
  end

  word_t t1, t2, t3, t4, u, v, m1, m2, m3, s;

  idea_mulmod #(.W(W)) u_mul1 (.a_i(x[0]), .b_i(k[0]), .y_o(t1));
  idea_mulmod #(.W(W)) u_mul4 (.a_i(x[3]), .b_i(k[3]), .y_o(t4));
  idea_mulmod #(.W(W)) u_mul5 (.a_i(u),    .b_i(k[4]), .y_o(m1));
  idea_mulmod #(.W(W)) u_mul6 (.a_i(s),    .b_i(k[5]), .y_o(m2));

  assign t2 = x[1] + k[1];
  assign t3 = x[2] + k[2];
  assign u  = t1 ^ t3;
  assign v  = t2 ^ t4;
  assign s  = m1 + v;
  assign m3 = m1 + m2;

  assign rnd_o = {t1 ^ m2, t3 ^ m2, t2 ^ m3, t4 ^ m3};
  // output step shares the outer multipliers
  assign xf_o  = {t1, x[2] + k[1], x[1] + k[2], t4};
endmodule

// File: rtl/idea_iter_enc.sv
module idea_iter_enc
  import idea_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [63:0]     pt_i,
  output logic [3:0]      key_idx_o,
  input  logic [95:0]     key_i,
  output logic [63:0]     ct_o,
  output logic            done_o
);
  localparam logic [IDXW-1:0] LAST = IDXW'(NROUND);

  logic            busy_q, done_q;
  logic [IDXW-1:0] step_q;
  logic [BLKW-1:0] state_q, ct_q, rnd, xf;

  idea_round u_round (
    .x_i  (state_q),
    .k_i  (key_i),
    .rnd_o(rnd),
    .xf_o (xf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      step_q  <= '0;
      state_q <= '0;
      ct_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q  <= 1'b1;
          state_q <= pt_i;
          step_q  <= '0;
        end
      end else if (step_q == LAST) begin
        ct_q   <= xf;
        done_q <= 1'b1;
        busy_q <= 1'b0;
        step_q <= '0;
      end else begin
        state_q <= rnd;
        step_q  <= step_q + 1'b1;
      end
    end
  end

  assign key_idx_o = 4'(step_q);
  assign ct_o      = ct_q;
  assign done_o    = done_q;

  a_r6_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r5_idx_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_idx_o <= 4'(NROUND));
  a_r5_idx_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && step_q != LAST) |=> (key_idx_o == $past(key_idx_o) + 4'd1));
  a_r7_busy_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && step_q != LAST) |=> busy_q);
  a_r8_ct_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ct_o) |-> done_o);
endmodule

// File: tb/idea_iter_enc_bench.sv
module idea_iter_enc_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [63:0] pt_i = '0;
  logic [3:0]  key_idx_o;
  logic [95:0] key_i;
  logic [63:0] ct_o;
  logic        done_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [15:0] sk [52];

  always #(CLK_PERIOD/2) clk = ~clk;

  idea_iter_enc u_idea_iter_enc (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .pt_i(pt_i),
    .key_idx_o(key_idx_o), .key_i(key_i), .ct_o(ct_o), .done_o(done_o)
  );

  // R5 packing: K1 at 95:80 .. K6 at 15:0
  always_comb begin
    key_i = '0;
    for (int j = 0; j < 6; j++) begin
      if (int'(key_idx_o) * 6 + j < 52)
        key_i[95-16*j -: 16] = sk[int'(key_idx_o) * 6 + j];
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic gen_keys(input logic [127:0] key);
    logic [127:0] k = key;
    for (int i = 0; i < 52; i++) begin
      if (i > 0 && i % 8 == 0) k = {k[102:0], k[127:103]};
      sk[i] = k[127 - 16*(i%8) -: 16];
    end
  endtask

  function automatic logic [15:0] mm(input logic [15:0] a, input logic [15:0] b);
    longint aa = (a == 0) ? 65536 : longint'(a);
    longint bb = (b == 0) ? 65536 : longint'(b);
    longint p  = (aa * bb) % 65537;
    return p[15:0];
  endfunction

  function automatic logic [63:0] model(input logic [63:0] pt);
    logic [15:0] x1 = pt[63:48], x2 = pt[47:32], x3 = pt[31:16], x4 = pt[15:0];
    logic [15:0] a, b, c, d, e, f, g;
    for (int r = 0; r < 8; r++) begin
      a = mm(x1, sk[6*r]);   b = x2 + sk[6*r+1];
      c = x3 + sk[6*r+2];    d = mm(x4, sk[6*r+3]);
      e = mm(a ^ c, sk[6*r+4]);
      f = mm(e + (b ^ d), sk[6*r+5]);
      g = e + f;
      x1 = a ^ f; x2 = c ^ f; x3 = b ^ g; x4 = d ^ g;
    end
    return {mm(x1, sk[48]), x3 + sk[49], x2 + sk[50], mm(x4, sk[51])};
  endfunction

  task automatic run(input logic [127:0] key, input logic [63:0] pt,
                     input bit inject, input bit has_lit, input logic [63:0] lit);
    logic [63:0] exp;
    int n;
    gen_keys(key);
    exp = model(pt);
    @(negedge clk); start_i = 1'b1; pt_i = pt;
    @(negedge clk); start_i = 1'b0; pt_i = ~pt;
    check("R5 idx at first step", 64'(key_idx_o), 64'd0);
    n = 0;
    while (!done_o && n < 40) begin
      @(negedge clk); n++;
      if (inject && n == 3) start_i = 1'b1;   // R7 mid-run strobe
      if (inject && n == 4) start_i = 1'b0;
      if (!done_o && n <= 8) check("R5 idx advance", 64'(key_idx_o), 64'(n));
      if (!done_o) check("R6 no early done", 64'(done_o), 64'd0);
    end
    start_i = 1'b0;
    check("R6 latency", 64'(n), 64'd9);
    check("R1 R3 R4 ciphertext", ct_o, exp);
    if (has_lit) check("R9 known vector", ct_o, lit);
    if (inject) check("R7 strobe ignored", ct_o, exp);
    @(negedge clk);
    check("R6 done single cycle", 64'(done_o), 64'd0);
    check("R5 idle idx", 64'(key_idx_o), 64'd0);
    repeat (3) @(negedge clk);
    check("R8 ct held", ct_o, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unused;
    unused = $urandom(32'd1234);
    for (int i = 0; i < 52; i++) sk[i] = '0;
    repeat (3) @(negedge clk);
    check("R8 reset done", 64'(done_o), 64'd0);
    check("R8 reset idx", 64'(key_idx_o), 64'd0);
    check("R8 reset ct", ct_o, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    run({16'd1, 16'd2, 16'd3, 16'd4, 16'd5, 16'd6, 16'd7, 16'd8},
        64'h0000_0001_0002_0003, 0, 1, 64'h11FB_ED2B_0198_6DE5);
    // R2 zero operands stand for 65536
    run('0, '0, 0, 0, '0);
    run('1, '1, 0, 0, '0);
    run('0, 64'hFFFF_0000_FFFF_0000, 0, 0, '0);
    run({8{16'h0001}}, 64'h0000_FFFF_0000_0001, 1, 0, '0);
    for (int t = 0; t < 20; t++) begin
      run({$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom}, t % 4 == 0, 0, '0);
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule